// File: doc/BRIEF.md
# Serial DMA Channel Request and Grant Controller

This block is the host end of a single-wire channel-passing DMA scheme. Each of two peripheral agents owns a pin pair: an active-low request line into the block and an active-low grant line out of it. An agent reports which DMA channels it wants by sending a frame on its request line. The frame is a low start bit followed by eight one-clock slots, one for each channel. The block records the latest report from each agent and discards requests for channels that are not routed to the serial style. It then picks one channel and sends the channel number back on that agent's grant line. At the same time it pulses a strobe that tells the DMA core which pair and which channel were granted.

A 16-bit routing register decides for each configurable channel whether the channel belongs to this serial path or to the other DMA path. Channel 4 is the cascade channel and is never served. Each pair allows only one grant at a time. A new grant on a pair waits until the DMA core returns a done pulse for that pair. Inputs are sampled on the rising clock edge. The asynchronous reset is released to the internal logic through a two-stage synchronizer, so the block leaves reset on the second rising edge after `rst_n` goes high.

Top module: `serdma_ctrl`

## Requirements
- R1: While reset is active, and right after it: both grant lines are high, `grant_stb` is 0, `dreq_vec` is 0 and `route_q` is 0.
- R2: A request frame begins with a low start bit. The eight samples that follow are slots for channels 0 to 7 in that order, and a high slot means the channel is requested. The edge after the last slot replaces the pair's stored requests with the frame contents, and `dreq_vec` bit i then shows channel i as requested.
- R3: A low sample is taken as a start bit only if the line was sampled high after reset or after the previous frame. A line held low from reset is never decoded.
- R4: `route_we` loads `route_wdata` into the routing register, and `route_q` reads it back. Field k sits at bits [2k+1:2k], for k = 0..6, and serves channels 0, 1, 2, 3, 5, 6 and 7 in that order. Field value 01 selects the serial path. Values 00, 10 and 11 select the other path. Bits 15:14 are always read as 0.
- R5: Requests on channels that are not routed to the serial path, and all requests on channel 4, are left out of `dreq_vec` and are never granted.
- R6: Within one pair, the lowest requested serial channel is granted first.
- R7: If both pairs could start a grant on the same edge, pair A (index 0) is granted first and pair B follows on the next edge.
- R8: A grant frame is a low start bit followed by channel bits 0, 1 and 2, least significant first. The line then returns high. `grant_stb` is high for one cycle with `grant_pair` and `grant_chan` in the same cycle as the start bit.
- R9: A pair starts no new grant frame until `dma_done` for that pair has pulsed after its previous grant.
- R10: A granted channel is removed from its pair's stored requests. Requests that are still pending are granted after the done pulse, and the next frame on that pair replaces the stored set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all sampling on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| route_we | input | 1 | Write strobe for the routing register |
| route_wdata | input | 16 | Value written into the routing register |
| route_q | output | 16 | Current routing register contents |
| sreq_n | input | 2 | Serial request lines, index 0 = pair A, index 1 = pair B |
| sgnt_n | output | 2 | Serial grant lines, same pair order |
| dma_done | input | 2 | Per-pair pulse from the DMA core ending the current grant |
| dreq_vec | output | 8 | Pending serial-routed requests of both pairs, bit per channel |
| grant_stb | output | 1 | One-cycle pulse when a grant frame starts |
| grant_pair | output | 1 | Pair of the grant being started |
| grant_chan | output | 3 | Channel of the grant being started |

## Verification
The bound checker watches every grant on every cycle. It checks that the grant line goes low together with the strobe and that the next bit is the channel LSB. It checks that the granted channel was routed to the serial path and is not channel 4. It checks that no pair receives a second grant before its done pulse, and that the reserved routing bits stay zero. The other properties depend on what was sent and which channel should win: frame decoding, masking under each routing setting, the lowest-channel choice, the pair ordering, and the refusal of a start bit that had no idle level before it. These can only be shown by the bench's sweeps, which send all 256 request patterns under several routing settings and compare the results with values computed from the requirements.

// File: rtl/serdma_pkg.sv
package serdma_pkg;
  localparam int NCH      = 8;
  localparam int CH_W     = $clog2(NCH);
  localparam int NPAIR    = 2;
  localparam int PAIR_W   = (NPAIR > 1) ? $clog2(NPAIR) : 1;
  localparam int NFIELD   = NCH - 1;
  localparam int CASCADE  = 4;
  localparam int ROUTE_W  = 16;
  localparam logic [1:0] RT_SERIAL = 2'b01;

  typedef enum logic [1:0] {
    RQ_WAITHI = 2'b00,
    RQ_READY  = 2'b01,
    RQ_SLOT   = 2'b10
  } rq_state_e;
endpackage

// File: rtl/serdma_route.sv
module serdma_route
  import serdma_pkg::*;
#(
  parameter int RW  = ROUTE_W,
  parameter int NC  = NCH,
  parameter int NF  = NFIELD,
  parameter int CAS = CASCADE
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [RW-1:0] wdata,
  output logic [RW-1:0] q,
  output logic [NC-1:0] serial_en
);
  localparam logic [RW-1:0] VALID_MASK = RW'((64'd1 << (2 * NF)) - 64'd1);

  logic [RW-1:0] route_q_r;
  logic [RW-1:0] route_nx;
  logic          route_ce;

  always_comb begin
    route_ce = we;
    route_nx = wdata & VALID_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      route_q_r <= '0;
    end else if (route_ce) begin
      route_q_r <= route_nx;
    end
  end

  always_comb begin
    serial_en = '0;
    for (int f = 0; f < NF; f++) begin
      serial_en[(f < CAS) ? f : f + 1] = (route_q_r[2*f +: 2] == RT_SERIAL);
    end
  end

  assign q = route_q_r;
endmodule

// File: rtl/serdma_reqdec.sv
module serdma_reqdec
  import serdma_pkg::*;
#(
  parameter int NC = NCH
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_n,
  output logic          frame_vld,
  output logic [NC-1:0] frame_bits
);
  localparam int CNT_W = $clog2(NC);

  rq_state_e         st_q, st_nx;
  logic [CNT_W-1:0]  cnt_q, cnt_nx;
  logic [NC-1:0]     sh_q, sh_nx, sh_ins;
  logic              sh_ce;

  always_comb begin
    st_nx      = st_q;
    cnt_nx     = cnt_q;
    sh_nx      = sh_q;
    sh_ce      = 1'b0;
    frame_vld  = 1'b0;
    sh_ins     = sh_q;
    sh_ins[cnt_q] = line_n;
    frame_bits = sh_ins;
    case (st_q)
      RQ_WAITHI: begin
        if (line_n) st_nx = RQ_READY;
      end
      RQ_READY: begin
        if (!line_n) begin
          st_nx  = RQ_SLOT;
          cnt_nx = '0;
          sh_nx  = '0;
          sh_ce  = 1'b1;
        end
      end
      RQ_SLOT: begin
        sh_nx  = sh_ins;
        sh_ce  = 1'b1;
        cnt_nx = cnt_q + 1'b1;
        if (cnt_q == CNT_W'(NC - 1)) begin
          frame_vld = 1'b1;
          st_nx     = RQ_WAITHI;
        end
      end
      default: st_nx = RQ_WAITHI;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= RQ_WAITHI;
      cnt_q <= '0;
    end else begin
      st_q  <= st_nx;
      cnt_q <= cnt_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else if (sh_ce) begin
      sh_q <= sh_nx;
    end
  end
endmodule

// File: rtl/serdma_gntser.sv
module serdma_gntser
  import serdma_pkg::*;
#(
  parameter int CW = CH_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] chan,
  output logic          line_n,
  output logic          idle
);
  localparam int LW = $clog2(CW + 2);

  logic [CW-1:0] bits_q, bits_nx;
  logic [LW-1:0] left_q, left_nx;
  logic          line_q, line_nx;
  logic          bits_ce;

  always_comb begin
    bits_nx = bits_q;
    bits_ce = 1'b0;
    left_nx = left_q;
    line_nx = 1'b1;
    if (load) begin
      line_nx = 1'b0;
      bits_nx = chan;
      bits_ce = 1'b1;
      left_nx = LW'(CW + 1);
    end else if (left_q != '0) begin
      left_nx = left_q - 1'b1;
      if (left_q != LW'(1)) begin
        line_nx = bits_q[0];
        bits_nx = bits_q >> 1;
        bits_ce = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
      line_q <= 1'b1;
    end else begin
      left_q <= left_nx;
      line_q <= line_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits_q <= '0;
    end else if (bits_ce) begin
      bits_q <= bits_nx;
    end
  end

  assign line_n = line_q;
  assign idle   = (left_q == '0);
endmodule

// File: rtl/serdma_arb.sv
module serdma_arb
  import serdma_pkg::*;
#(
  parameter int NC = NCH,
  parameter int NP = NPAIR,
  parameter int CW = CH_W,
  parameter int PW = PAIR_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NP-1:0]          frame_vld,
  input  logic [NP-1:0][NC-1:0]  frame_bits,
  input  logic [NC-1:0]          serial_en,
  input  logic [NP-1:0]          ser_idle,
  input  logic [NP-1:0]          done,
  output logic [NC-1:0]          dreq_vec,
  output logic [NP-1:0]          launch,
  output logic [CW-1:0]          launch_chan,
  output logic                   grant_stb,
  output logic [PW-1:0]          grant_pair,
  output logic [CW-1:0]          grant_chan
);
  logic [NP-1:0][NC-1:0] pend_q, pend_nx, elig;
  logic [NP-1:0][CW-1:0] lo;
  logic [NP-1:0]         busy_q, busy_nx, can;
  logic [PW-1:0]         sel;
  logic                  found;
  logic                  stb_q;
  logic [PW-1:0]         pair_q;
  logic [CW-1:0]         chan_q;

  always_comb begin
    dreq_vec = '0;
    for (int p = 0; p < NP; p++) begin
      elig[p]  = pend_q[p] & serial_en;
      can[p]   = !busy_q[p] && ser_idle[p] && (elig[p] != '0);
      dreq_vec = dreq_vec | elig[p];
      lo[p]    = '0;
      for (int c = NC - 1; c >= 0; c--) begin
        if (elig[p][c]) lo[p] = CW'(c);
      end
    end
  end

  always_comb begin
    found = 1'b0;
    sel   = '0;
    for (int p = NP - 1; p >= 0; p--) begin
      if (can[p]) begin
        found = 1'b1;
        sel   = PW'(p);
      end
    end
    launch_chan = lo[sel];
    launch      = '0;
    if (found) launch[sel] = 1'b1;
  end

  always_comb begin
    for (int p = 0; p < NP; p++) begin
      pend_nx[p] = frame_vld[p] ? frame_bits[p] : pend_q[p];
      if (launch[p]) pend_nx[p][launch_chan] = 1'b0;
      if (launch[p])      busy_nx[p] = 1'b1;
      else if (done[p])   busy_nx[p] = 1'b0;
      else                busy_nx[p] = busy_q[p];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      busy_q <= '0;
      stb_q  <= 1'b0;
    end else begin
      pend_q <= pend_nx;
      busy_q <= busy_nx;
      stb_q  <= found;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pair_q <= '0;
      chan_q <= '0;
    end else if (found) begin
      pair_q <= sel;
      chan_q <= launch_chan;
    end
  end

  assign grant_stb  = stb_q;
  assign grant_pair = pair_q;
  assign grant_chan = chan_q;
endmodule

// File: rtl/serdma_ctrl.sv
module serdma_ctrl
  import serdma_pkg::*;
#(
  parameter int NC = NCH,
  parameter int NP = NPAIR,
  parameter int CW = CH_W,
  parameter int PW = PAIR_W,
  parameter int RW = ROUTE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          route_we,
  input  logic [RW-1:0] route_wdata,
  output logic [RW-1:0] route_q,
  input  logic [NP-1:0] sreq_n,
  output logic [NP-1:0] sgnt_n,
  input  logic [NP-1:0] dma_done,
  output logic [NC-1:0] dreq_vec,
  output logic          grant_stb,
  output logic [PW-1:0] grant_pair,
  output logic [CW-1:0] grant_chan
);
  logic [1:0]            rsync_q;
  logic                  rst_core_n;
  logic [NC-1:0]         serial_en;
  logic [NP-1:0]         frame_vld;
  logic [NP-1:0][NC-1:0] frame_bits;
  logic [NP-1:0]         ser_idle;
  logic [NP-1:0]         launch;
  logic [CW-1:0]         launch_chan;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_core_n = rsync_q[1];

  serdma_route #(.RW(RW), .NC(NC), .NF(NC - 1), .CAS(CASCADE)) u_route (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .we        (route_we),
    .wdata     (route_wdata),
    .q         (route_q),
    .serial_en (serial_en)
  );

  for (genvar p = 0; p < NP; p++) begin : g_pair
    serdma_reqdec #(.NC(NC)) u_dec (
      .clk        (clk),
      .rst_n      (rst_core_n),
      .line_n     (sreq_n[p]),
      .frame_vld  (frame_vld[p]),
      .frame_bits (frame_bits[p])
    );

    serdma_gntser #(.CW(CW)) u_ser (
      .clk    (clk),
      .rst_n  (rst_core_n),
      .load   (launch[p]),
      .chan   (launch_chan),
      .line_n (sgnt_n[p]),
      .idle   (ser_idle[p])
    );
  end

  serdma_arb #(.NC(NC), .NP(NP), .CW(CW), .PW(PW)) u_arb (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .frame_vld   (frame_vld),
    .frame_bits  (frame_bits),
    .serial_en   (serial_en),
    .ser_idle    (ser_idle),
    .done        (dma_done),
    .dreq_vec    (dreq_vec),
    .launch      (launch),
    .launch_chan (launch_chan),
    .grant_stb   (grant_stb),
    .grant_pair  (grant_pair),
    .grant_chan  (grant_chan)
  );
endmodule

// File: rtl/serdma_ctrl_chk.sv
module serdma_ctrl_chk
  import serdma_pkg::*;
#(
  parameter int NP = NPAIR,
  parameter int CW = CH_W,
  parameter int PW = PAIR_W,
  parameter int RW = ROUTE_W
) (
  input logic          clk,
  input logic          rst_n,
  input logic [NP-1:0] sgnt_n,
  input logic [NP-1:0] dma_done,
  input logic          grant_stb,
  input logic [PW-1:0] grant_pair,
  input logic [CW-1:0] grant_chan,
  input logic [RW-1:0] route_q
);
  logic [RW-1:0] route_d;
  logic [NP-1:0] inflight_q;
  logic          chan_routed;
  int            fld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      route_d    <= '0;
      inflight_q <= '0;
    end else begin
      route_d <= route_q;
      for (int p = 0; p < NP; p++) begin
        if (dma_done[p])                            inflight_q[p] <= 1'b0;
        else if (grant_stb && grant_pair == PW'(p)) inflight_q[p] <= 1'b1;
      end
    end
  end

  always_comb begin
    fld = (int'(grant_chan) < CASCADE) ? int'(grant_chan) : int'(grant_chan) - 1;
    chan_routed = (int'(grant_chan) != CASCADE) && (route_d[2*fld +: 2] == RT_SERIAL);
  end

  AST_GNT_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    grant_stb |-> !sgnt_n[grant_pair]);                                   // R8
  AST_GNT_FIRST_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    grant_stb |=> sgnt_n[$past(grant_pair)] == $past(grant_chan[0]));     // R8
  AST_NO_CASCADE: assert property (@(posedge clk) disable iff (!rst_n)
    grant_stb |-> int'(grant_chan) != CASCADE);                           // R5
  AST_ROUTED_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    grant_stb |-> chan_routed);                                           // R5
  AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    grant_stb |-> !inflight_q[grant_pair]);                               // R9
  AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    grant_stb |=> !(grant_stb && grant_pair == $past(grant_pair)));       // R9
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    route_q[RW-1:RW-2] == 2'b00);                                         // R4
endmodule

bind serdma_ctrl serdma_ctrl_chk #(.NP(NP), .CW(CW), .PW(PW), .RW(RW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sgnt_n     (sgnt_n),
  .dma_done   (dma_done),
  .grant_stb  (grant_stb),
  .grant_pair (grant_pair),
  .grant_chan (grant_chan),
  .route_q    (route_q)
);

// File: tb/sim_serdma_ctrl.sv
`timescale 1ns/1ps
module sim_serdma_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        route_we = 1'b0;
  logic [15:0] route_wdata = '0;
  logic [15:0] route_q;
  logic [1:0]  sreq_n = 2'b11;
  logic [1:0]  sgnt_n;
  logic [1:0]  dma_done = 2'b00;
  logic [7:0]  dreq_vec;
  logic        grant_stb;
  logic        grant_pair;
  logic [2:0]  grant_chan;

  int n_chk = 0;
  int n_fail = 0;
  int stb_cnt = 0;

  always #2.5 clk = ~clk;

  serdma_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .route_we(route_we), .route_wdata(route_wdata),
    .route_q(route_q), .sreq_n(sreq_n), .sgnt_n(sgnt_n), .dma_done(dma_done),
    .dreq_vec(dreq_vec), .grant_stb(grant_stb), .grant_pair(grant_pair),
    .grant_chan(grant_chan)
  );

  always @(negedge clk) if (grant_stb) stb_cnt++;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_en(input logic [15:0] rt);
    logic [7:0] en = '0;
    for (int f = 0; f < 7; f++) en[(f < 4) ? f : f + 1] = (rt[2*f +: 2] == 2'b01);
    return en;
  endfunction

  function automatic int lowest(input logic [7:0] v);
    for (int c = 0; c < 8; c++) if (v[c]) return c;
    return -1;
  endfunction

  task automatic write_route(input logic [15:0] v);
    @(negedge clk); route_we = 1'b1; route_wdata = v;
    @(negedge clk); route_we = 1'b0;
  endtask

  task automatic send_both(input logic [1:0] pm, input logic [7:0] va, input logic [7:0] vb);
    @(negedge clk);
    if (pm[0]) sreq_n[0] = 1'b0;
    if (pm[1]) sreq_n[1] = 1'b0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (pm[0]) sreq_n[0] = va[i];
      if (pm[1]) sreq_n[1] = vb[i];
    end
    @(negedge clk); sreq_n = 2'b11;
  endtask

  task automatic pulse_done(input int p);
    @(negedge clk); dma_done[p] = 1'b1;
    @(negedge clk); dma_done[p] = 1'b0;
  endtask

  task automatic expect_grant(input int p, input int ch, input string tag);
    bit seen = 0;
    for (int i = 0; i < 12 && !seen; i++) begin
      @(negedge clk);
      if (grant_stb) seen = 1;
    end
    chk(seen, {tag, " strobe"}, seen, 1);
    if (seen) begin
      chk(grant_pair == p[0], {tag, " pair"}, grant_pair, p);
      chk(grant_chan == ch[2:0], {tag, " chan"}, grant_chan, ch);
      chk(sgnt_n[p] == 1'b0, "R8 start bit", sgnt_n[p], 0);
      for (int b = 0; b < 3; b++) begin
        @(negedge clk);
        chk(sgnt_n[p] == ch[b], "R8 channel bit", sgnt_n[p], ch[b]);
      end
      @(negedge clk);
      chk(sgnt_n[p] == 1'b1, "R8 return high", sgnt_n[p], 1);
    end
  endtask

  task automatic expect_none(input string tag, input int cycles);
    int c0 = stb_cnt;
    repeat (cycles) @(negedge clk);
    chk(stb_cnt == c0, tag, stb_cnt - c0, 0);
  endtask

  task automatic run_sweep(input int p, input logic [15:0] rt);
    logic [7:0] en = exp_en(rt);
    logic [1:0] pm = (p == 0) ? 2'b01 : 2'b10;
    write_route(rt);
    chk(route_q == rt, "R4 readback", route_q, rt);
    for (int v = 0; v < 256; v++) begin
      int low;
      int c0;
      send_both(pm, v[7:0], v[7:0]);
      chk(dreq_vec == (v[7:0] & en), "R2 R5 dreq_vec", dreq_vec, v[7:0] & en);
      low = lowest(v[7:0] & en);
      if (low >= 0) expect_grant(p, low, "R6 lowest");
      else          expect_none("R5 masked no grant", 6);
      c0 = stb_cnt;
      send_both(pm, 8'h00, 8'h00);
      chk(stb_cnt == c0, "R9 held while busy", stb_cnt - c0, 0);
      chk(dreq_vec == 8'h00, "R10 replaced by frame", dreq_vec, 0);
      pulse_done(p);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    sreq_n = 2'b10;
    repeat (3) @(negedge clk);
    chk(sgnt_n == 2'b11, "R1 grant lines", sgnt_n, 3);
    chk(grant_stb == 1'b0, "R1 strobe", grant_stb, 0);
    chk(dreq_vec == 8'h00, "R1 dreq_vec", dreq_vec, 0);
    chk(route_q == 16'h0000, "R1 route", route_q, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(sgnt_n == 2'b11, "R1 after release", sgnt_n, 3);
    write_route(16'h1555);
    sreq_n = 2'b11;
    expect_none("R3 no start without idle", 14);
    chk(dreq_vec == 8'h00, "R3 dreq_vec", dreq_vec, 0);

    write_route(16'hFFFF);
    chk(route_q == 16'h3FFF, "R4 reserved bits", route_q, 16'h3FFF);
    write_route(16'h1A65);
    chk(route_q == 16'h1A65, "R4 mixed", route_q, 16'h1A65);

    run_sweep(0, 16'h1555);
    run_sweep(0, 16'h1A65);
    run_sweep(0, 16'h3FFF);
    run_sweep(1, 16'h1555);

    write_route(16'h1555);
    send_both(2'b11, 8'b0000_1100, 8'b0000_0011);
    @(negedge clk);
    chk(grant_stb && grant_pair == 1'b0, "R7 pair A first", grant_pair, 0);
    chk(grant_chan == 3'd2, "R7 chan A", grant_chan, 2);
    chk(sgnt_n == 2'b10, "R7 lines", sgnt_n, 2'b10);
    @(negedge clk);
    chk(grant_stb && grant_pair == 1'b1, "R7 pair B next", grant_pair, 1);
    chk(grant_chan == 3'd0, "R7 chan B", grant_chan, 0);
    chk(sgnt_n == 2'b00, "R7 lines t1", sgnt_n, 0);
    @(negedge clk);
    chk(sgnt_n == 2'b01, "R8 lines t2", sgnt_n, 1);
    @(negedge clk);
    chk(sgnt_n == 2'b00, "R8 lines t3", sgnt_n, 0);
    @(negedge clk);
    chk(sgnt_n == 2'b01, "R8 lines t4", sgnt_n, 1);
    @(negedge clk);
    chk(sgnt_n == 2'b11, "R8 lines t5", sgnt_n, 3);
    chk(dreq_vec == 8'b0000_1010, "R10 remaining pending", dreq_vec, 8'h0A);
    expect_none("R9 no grant before done", 10);
    pulse_done(0);
    expect_grant(0, 3, "R10 next after done A");
    pulse_done(1);
    expect_grant(1, 1, "R10 next after done B");
    pulse_done(0);
    pulse_done(1);
    expect_none("R10 pending drained", 8);

    send_both(2'b01, 8'h80, 8'h00);
    expect_grant(0, 7, "R6 single channel 7");
    send_both(2'b01, 8'h01, 8'h00);
    expect_none("R9 busy pair", 8);
    pulse_done(0);
    expect_grant(0, 0, "R9 granted after done");
    pulse_done(0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule